// File: doc/BRIEF.md
# Programmable DDR2 Init Sequencer

This block plays back a table of DRAM power-up commands that software loads before memory can be used. The table has fourteen slots. Each slot carries an enable flag, the three command strobes, a bank/mode-register select, the address or mode bits, and a wait count in memory-clock cycles. When an execute request arrives, the block drives each enabled slot's command onto the DRAM command bus in slot order. After each command it holds the bus at NOP, with chip select asserted, for that slot's wait count.

A completion flag stays low from the moment a run is accepted until the last wait has expired. The normal-operation enable that software requests is passed on to the rest of the memory controller only while that flag is high. This lets software set both bits early without the controller running ahead of DRAM initialization.

A typical table holds the following steps in order:
- a NOP with a long settle wait;
- a precharge-all;
- writes to the three extended mode registers;
- a mode-register write with DLL reset and a long wait;
- a second precharge-all;
- four refreshes;
- the closing mode and extended-mode writes, which enter and then leave off-chip-driver calibration.

Top module: `ddr_init_seq`

## Requirements
- R1: A slot written through the configuration port is stored with this layout: bit 28 enable, bits 27:25 {RAS#, CAS#, WE#}, bits 24:22 bank select, bits 21:8 address, bits 7:0 wait count. The stored fields appear unchanged on the bus when that slot is issued.
- R2: After reset, chip select, RAS#, CAS# and WE# are all high, the completion flag is low and the controller enable is low.
- R3: An execute request sampled while idle places the first enabled slot's command on the bus in the following cycle.
- R4: Enabled slots are issued in ascending slot order. Each command occupies the bus for exactly one cycle, with chip select low.
- R5: After a command whose wait count is W, the bus shows exactly W NOP cycles (chip select low, RAS#, CAS# and WE# high) before the next command.
- R6: A slot with wait count zero is followed by the next command in the very next cycle.
- R7: A slot whose enable bit is clear issues no command and adds no cycles to the run.
- R8: The completion flag is low throughout a run. It goes high in the cycle after the last wait cycle and stays high until the next accepted execute request.
- R9: An execute request that arrives while a run is in progress has no effect on the command stream.
- R10: The controller enable is high only when it is requested and the completion flag is high.
- R11: While idle, chip select is deasserted (high).
- R12: An execute request with no slot enabled issues no command, and the completion flag is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_idx | input | 4 | Slot index to write |
| cfg_entry | input | 29 | Slot contents (layout in R1) |
| exec_req | input | 1 | Start a run when idle |
| ctl_en_req | input | 1 | Requested normal-operation enable |
| cs_n | output | 1 | DRAM chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| ba | output | 3 | Bank / mode-register select |
| addr | output | 14 | Address / mode bits |
| init_done | output | 1 | Completion flag |
| ctl_en | output | 1 | Gated controller enable |

## Verification
The full fourteen-slot power-up table is played back once with long waits, which checks command order and the exact idle gap after every command. Tables with some slots disabled show whether skipped slots leak cycles. A table with all-zero waits shows whether commands run back to back. A table with nothing enabled tests the empty case. Random tables with random enables and short waits, some with an execute pulse injected mid-run, separate order errors, off-by-one waits and restart bugs. Every bus cycle is compared against a stream the bench derives from its own copy of the table.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    parameter int NUM_ENTRIES = 14;
    parameter int ADDR_W      = 14;
    parameter int BA_W        = 3;
    parameter int WAIT_W      = 8;

    localparam int IDX_W   = $clog2(NUM_ENTRIES);
    localparam int ENTRY_W = 1 + 3 + BA_W + ADDR_W + WAIT_W;

    typedef struct packed {
        logic              en;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic [WAIT_W-1:0] dly;
    } entry_t;

    typedef struct packed {
        logic              cs_n;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
    } bus_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } nxt_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CMD  = 2'd1,
        SQ_HOLD = 2'd2
    } sq_state_e;

    localparam bus_t BUS_DESELECT = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                      we_n: 1'b1, ba: '0, addr: '0};
    localparam bus_t BUS_NOP      = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1,
                                      we_n: 1'b1, ba: '0, addr: '0};

    // lowest enabled slot at or above start
    function automatic nxt_t find_next(input logic [NUM_ENTRIES-1:0] en,
                                       input int start);
        nxt_t r;
        r.hit = 1'b0;
        r.idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (en[i] && (i >= start)) begin
                r.hit = 1'b1;
                r.idx = IDX_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ddr_init_table.sv
module ddr_init_table
    import ddr_init_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  entry_t                 wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output entry_t                 rd_entry,
    output logic [NUM_ENTRIES-1:0] en_vec
);

    entry_t slots [NUM_ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENTRIES; i++) slots[i] <= '0;
        end else if (wr_en && (int'(wr_idx) < NUM_ENTRIES)) begin
            slots[wr_idx] <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_en
        assign en_vec[g] = slots[g].en;
    end

    always_comb begin
        rd_entry = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (int'(rd_idx) == i) rd_entry = slots[i];
        end
    end

endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
    import ddr_init_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   exec_req,
    input  logic [NUM_ENTRIES-1:0] en_vec,
    input  entry_t                 cur,
    output logic [IDX_W-1:0]       idx,
    output bus_t                   bus,
    output logic                   done,
    output logic                   busy,
    output sq_state_e              state,
    output logic [WAIT_W-1:0]      cnt
);

    nxt_t first_hit;
    nxt_t next_hit;
    logic step;

    assign first_hit = find_next(en_vec, 0);
    assign next_hit  = find_next(en_vec, int'(idx) + 1);

    // the current slot's post-command wait ends this cycle
    assign step = ((state == SQ_CMD)  && (cur.dly == '0)) ||
                  ((state == SQ_HOLD) && (cnt == WAIT_W'(1)));

    assign busy = (state != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            idx   <= '0;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (exec_req) begin
                        if (first_hit.hit) begin
                            state <= SQ_CMD;
                            idx   <= first_hit.idx;
                            done  <= 1'b0;
                        end else begin
                            done  <= 1'b1;
                        end
                    end
                end
                SQ_CMD: begin
                    if (!step) begin
                        cnt   <= cur.dly;
                        state <= SQ_HOLD;
                    end
                end
                SQ_HOLD: begin
                    if (!step) cnt <= cnt - WAIT_W'(1);
                end
                default: state <= SQ_IDLE;
            endcase

            if (step) begin
                if (next_hit.hit) begin
                    idx   <= next_hit.idx;
                    state <= SQ_CMD;
                end else begin
                    state <= SQ_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (state)
            SQ_CMD: begin
                bus.cs_n  = 1'b0;
                bus.ras_n = cur.ras_n;
                bus.cas_n = cur.cas_n;
                bus.we_n  = cur.we_n;
                bus.ba    = cur.ba;
                bus.addr  = cur.addr;
            end
            SQ_HOLD: bus = BUS_NOP;
            default: bus = BUS_DESELECT;
        endcase
    end

endmodule

// File: rtl/ddr_init_gate.sv
module ddr_init_gate (
    input  logic req,
    input  logic done,
    input  logic busy,
    output logic en
);

    assign en = req & done & ~busy;

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [ENTRY_W-1:0]   cfg_entry,
    input  logic                 exec_req,
    input  logic                 ctl_en_req,
    output logic                 cs_n,
    output logic                 ras_n,
    output logic                 cas_n,
    output logic                 we_n,
    output logic [BA_W-1:0]      ba,
    output logic [ADDR_W-1:0]    addr,
    output logic                 init_done,
    output logic                 ctl_en
);

    entry_t                 cur;
    logic [NUM_ENTRIES-1:0] en_vec;
    logic [IDX_W-1:0]       rd_idx;
    bus_t                   bus;
    logic                   busy;
    sq_state_e              seq_state;
    logic [WAIT_W-1:0]      seq_cnt;

    ddr_init_table u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_data  (entry_t'(cfg_entry)),
        .rd_idx   (rd_idx),
        .rd_entry (cur),
        .en_vec   (en_vec)
    );

    ddr_init_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .exec_req (exec_req),
        .en_vec   (en_vec),
        .cur      (cur),
        .idx      (rd_idx),
        .bus      (bus),
        .done     (init_done),
        .busy     (busy),
        .state    (seq_state),
        .cnt      (seq_cnt)
    );

    ddr_init_gate u_gate (
        .req  (ctl_en_req),
        .done (init_done),
        .busy (busy),
        .en   (ctl_en)
    );

    assign cs_n  = bus.cs_n;
    assign ras_n = bus.ras_n;
    assign cas_n = bus.cas_n;
    assign we_n  = bus.we_n;
    assign ba    = bus.ba;
    assign addr  = bus.addr;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk
    import ddr_init_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   exec_req,
    input logic                   cs_n,
    input logic                   ras_n,
    input logic                   cas_n,
    input logic                   we_n,
    input logic                   init_done,
    input logic                   ctl_en,
    input logic                   busy,
    input logic [NUM_ENTRIES-1:0] en_vec,
    input sq_state_e              seq_state,
    input logic [WAIT_W-1:0]      seq_cnt
);

    AST_HOLD_IS_NOP: assert property (@(posedge clk) disable iff (rst)
        (seq_state == SQ_HOLD) |-> (!cs_n && ras_n && cas_n && we_n)); // R5

    AST_HOLD_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        ((seq_state == SQ_HOLD) && ($past(seq_state) == SQ_HOLD))
        |-> (seq_cnt == $past(seq_cnt) - WAIT_W'(1))); // R5

    AST_DONE_LOW_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !init_done); // R8

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n); // R11

    AST_CTL_EN_GATED: assert property (@(posedge clk) disable iff (rst)
        ctl_en |-> (init_done && cs_n)); // R10

    AST_EXEC_STARTS: assert property (@(posedge clk) disable iff (rst)
        (!busy && exec_req && (en_vec != '0)) |=> (busy && !init_done && !cs_n)); // R3

    AST_EXEC_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (!busy && exec_req && (en_vec == '0)) |=> (init_done && cs_n)); // R12

endmodule

bind ddr_init_seq ddr_init_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .exec_req  (exec_req),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .init_done (init_done),
    .ctl_en    (ctl_en),
    .busy      (busy),
    .en_vec    (en_vec),
    .seq_state (seq_state),
    .seq_cnt   (seq_cnt)
);

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;
    import ddr_init_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic cfg_we;
    logic [IDX_W-1:0] cfg_idx;
    logic [ENTRY_W-1:0] cfg_entry;
    logic exec_req;
    logic ctl_en_req;
    logic cs_n, ras_n, cas_n, we_n;
    logic [BA_W-1:0] ba;
    logic [ADDR_W-1:0] addr;
    logic init_done, ctl_en;

    always #5 clk = ~clk;

    ddr_init_seq uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_entry(cfg_entry), .exec_req(exec_req), .ctl_en_req(ctl_en_req),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(init_done), .ctl_en(ctl_en)
    );

    int checks = 0;
    int fails  = 0;
    entry_t mdl [NUM_ENTRIES];
    bus_t exp_q [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic bus_t observed();
        bus_t b;
        b.cs_n = cs_n; b.ras_n = ras_n; b.cas_n = cas_n; b.we_n = we_n;
        b.ba = ba; b.addr = addr;
        return b;
    endfunction

    function automatic entry_t mk(input bit en, input logic [2:0] cmd,
                                  input int bsel, input int a, input int w);
        entry_t e;
        e.en = en;
        {e.ras_n, e.cas_n, e.we_n} = cmd;
        e.ba = BA_W'(bsel);
        e.addr = ADDR_W'(a);
        e.dly = WAIT_W'(w);
        return e;
    endfunction

    task automatic load(input int i, input entry_t e);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(i); cfg_entry = e;
        @(negedge clk);
        cfg_we = 1'b0;
        mdl[i] = e;
    endtask

    // expected bus stream from the bench's own copy of the table
    task automatic build_expect();
        bus_t c;
        exp_q.delete();
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (mdl[i].en) begin
                c.cs_n = 1'b0; c.ras_n = mdl[i].ras_n; c.cas_n = mdl[i].cas_n;
                c.we_n = mdl[i].we_n; c.ba = mdl[i].ba; c.addr = mdl[i].addr;
                exp_q.push_back(c);
                for (int k = 0; k < int'(mdl[i].dly); k++) exp_q.push_back(BUS_NOP);
            end
        end
    endtask

    task automatic run_seq(input string req, input int poke_at);
        bus_t b;
        build_expect();
        @(negedge clk);
        exec_req = 1'b1;
        @(negedge clk);
        exec_req = 1'b0;
        for (int c = 0; c < exp_q.size(); c++) begin
            exec_req = (c == poke_at);
            b = observed();
            check(b == exp_q[c], req, $sformatf("bus cycle %0d", c), 64'(b), 64'(exp_q[c]));
            check(!init_done, "R8", "done low during run", 64'(init_done), 64'(0));
            if (ctl_en_req)
                check(!ctl_en, "R10", "enable held during run", 64'(ctl_en), 64'(0));
            @(negedge clk);
        end
        exec_req = 1'b0;
        check(init_done, "R8", "done after last wait", 64'(init_done), 64'(1));
        check(cs_n, "R11", "deselect when idle", 64'(cs_n), 64'(1));
    endtask

    initial begin
        #(200000 * 10);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        entry_t e;
        void'($urandom(32'd24681357));
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_entry = '0;
        exec_req = 1'b0; ctl_en_req = 1'b1;
        for (int i = 0; i < NUM_ENTRIES; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        // R2: reset state
        check({cs_n, ras_n, cas_n, we_n} == 4'hF, "R2", "strobes after reset",
              64'({cs_n, ras_n, cas_n, we_n}), 64'hF);
        check(!init_done, "R2", "done after reset", 64'(init_done), 64'(0));
        check(!ctl_en, "R2", "enable after reset", 64'(ctl_en), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        check(cs_n, "R11", "idle deselect", 64'(cs_n), 64'(1));

        // R1 / R4 / R5: full power-up table (NOP=111 PRE=010 MRS=000 REF=001)
        load(0,  mk(1, 3'b111, 0, 0,      106));
        load(1,  mk(1, 3'b010, 0, 'h400,  4));
        load(2,  mk(1, 3'b000, 2, 0,      2));
        load(3,  mk(1, 3'b000, 3, 0,      2));
        load(4,  mk(1, 3'b000, 1, 'h004,  2));
        load(5,  mk(1, 3'b000, 0, 'h532,  200));
        load(6,  mk(1, 3'b010, 0, 'h400,  4));
        load(7,  mk(1, 3'b001, 0, 0,      25));
        load(8,  mk(1, 3'b001, 0, 0,      25));
        load(9,  mk(1, 3'b001, 0, 0,      25));
        load(10, mk(1, 3'b001, 0, 0,      25));
        load(11, mk(1, 3'b000, 0, 'h432,  2));
        load(12, mk(1, 3'b000, 1, 'h384,  2));
        load(13, mk(1, 3'b000, 1, 'h004,  2));
        check(!ctl_en, "R10", "enable before any run", 64'(ctl_en), 64'(0));
        run_seq("R1 R3 R4 R5", -1);
        check(ctl_en, "R10", "enable after done", 64'(ctl_en), 64'(1));
        ctl_en_req = 1'b0;
        #1;
        check(!ctl_en, "R10", "enable withdrawn", 64'(ctl_en), 64'(0));
        repeat (5) @(negedge clk);
        check(init_done, "R8", "done holds while idle", 64'(init_done), 64'(1));

        // R9: execute pulse mid-run changes nothing
        run_seq("R9", 150);

        // R7: disabled slots skipped
        e = mdl[1]; e.en = 1'b0; load(1, e);
        e = mdl[5]; e.en = 1'b0; load(5, e);
        e = mdl[13]; e.en = 1'b0; load(13, e);
        run_seq("R7", -1);

        // R6: zero waits back to back
        for (int i = 0; i < NUM_ENTRIES; i++)
            load(i, mk(1, 3'(i % 7), i % 8, i * 37 + 5, 0));
        run_seq("R6", -1);

        // R12: nothing enabled
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            e = mdl[i]; e.en = 1'b0; load(i, e);
        end
        run_seq("R12", -1);

        // random tables
        for (int r = 0; r < 20; r++) begin
            for (int i = 0; i < NUM_ENTRIES; i++)
                load(i, mk(($urandom % 4) != 0, 3'($urandom), int'($urandom % 8),
                           int'($urandom % 16384), int'($urandom % 6)));
            build_expect();
            run_seq("R4", (r % 3 == 0 && exp_q.size() > 2) ? 1 : -1);
        end

        summary();
        $finish;
    end

endmodule